// File: doc/BRIEF.md
# Serial Flash Status Poller

This block reads the status byte of up to four serial flash devices. It does the reading through a byte-level SPI master. It has two jobs, chosen by `mode` when `start` is pulsed.

The scan job (`mode`=0) is a presence and density check. It visits each attached device in turn and stops at the first device whose density field is below the expected code. The wait job (`mode`=1) selects one device and keeps reading its status until the device reports ready. It stops early with a timeout if the number of busy reads reaches a parameter limit.

Each status read is a short transaction. The block lowers the device's chip select and sends the status opcode 0xD7 once. It then sends one dummy byte 0xFF for every status sample, and the byte returned during that dummy transfer is the status.

The byte interface to the SPI master is a stream of the valid/ready kind. `tx_valid` and `tx_data` stay stable until `tx_ready` is seen. After each accepted byte, the master returns exactly one `rx_valid` pulse, one cycle wide, carrying the byte clocked in. The poller has no receive back-pressure: it takes `rx_data` in any cycle `rx_valid` is high. Only one byte is outstanding at a time.

Top module: `flash_stat_poll`

## Requirements
- R1: After reset, and whenever no job is running, `cs_n` is all ones, `tx_valid`, `busy` and `done` are low.
- R2: Every selection of a device begins with exactly one transmitted byte 0xD7. Every later byte under that selection is 0xFF, and each status sample is the `rx_data` returned for a 0xFF byte.
- R3: `tx_valid` and `tx_data` hold steady until `tx_ready` is high. No new byte is offered before the `rx_valid` of the previous one.
- R4: `cs_n` is active low and at most one-hot: bit i selects device i, and a byte is only offered while some device is selected.
- R5: In scan mode, devices are selected in increasing index order from 0. Each device gets its own selection, and `cs_n` returns to all ones between devices.
- R6: In scan mode a device fails when (status AND 0x3C) is less than `DENS_CODE`. Status bits outside 0x3C, including bit 7, have no effect. The scan stops at the first failing device with `fail`=1, and reports `pass`=1 only when every device up to `DEV_CNT`-1 passes.
- R7: In wait mode, device `dev_idx` is selected once and stays selected across every status sample. Sampling repeats while status bit 7 is 0, and the job ends with `pass`=1 on the first sample with bit 7 set to 1.
- R8: In wait mode with `POLL_LIMIT`>0, the job ends with `fail`=1 and `timeout`=1 after `POLL_LIMIT` busy samples. `POLL_LIMIT`=0 removes the limit.
- R9: A wait-mode start with `dev_idx` >= `DEV_CNT` completes at once with `fail`=1, with no selection and no byte sent.
- R10: A `start` pulse while `busy` is high is ignored and does not change the result or the bytes sent.
- R11: `done` is a one-cycle pulse. At `done`, exactly one of `pass` and `fail` is 1. `pass`, `fail` and `timeout` hold until the next accepted start, and `timeout` is 1 only together with `fail`.
- R12: `DEV_CNT` outside 1..4 is an elaboration error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job request pulse |
| mode | input | 1 | 0 = scan all devices, 1 = wait on one device |
| dev_idx | input | 2 | Device for wait mode |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result: success |
| fail | output | 1 | Result: failure |
| timeout | output | 1 | Result: poll limit reached |
| tx_valid | output | 1 | Byte offered to the SPI master |
| tx_ready | input | 1 | SPI master accepts the byte |
| tx_data | output | 8 | Byte to send |
| rx_valid | input | 1 | Received byte is present (one cycle) |
| rx_data | input | 8 | Byte clocked in during the accepted transfer |
| cs_n | output | DEV_CNT | Per-device chip selects, active low |

## Verification
The assertions take for granted that the SPI master returns one single-cycle `rx_valid` for each accepted byte, and never sends one unprompted. They also take for granted that `tx_ready` may drop at any time while `tx_valid` is high. The bench's responder model keeps to this: it lowers `tx_ready` as soon as it accepts a byte, answers after a programmable latency, and only then raises `tx_ready` again. The sweeps cover both a zero-latency and a stalling responder. They walk every failing position in the scan, density values on both sides of the threshold with noise in the masked-off bits, and busy counts up to and past the poll limit for every device index.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int          MAX_DEV   = 4;
  localparam int          IDX_W     = 2;
  localparam logic [7:0]  OP_STATUS = 8'hD7;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;
  localparam logic [7:0]  DENS_MASK = 8'h3C;
  localparam int          READY_BIT = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_CMD,
    S_CMD_RX,
    S_DUMMY,
    S_STAT,
    S_GAP
  } fsp_state_e;

  typedef enum logic {
    M_CHECK = 1'b0,
    M_WAIT  = 1'b1
  } fsp_mode_e;
endpackage

// File: rtl/fsp_cs_decode.sv
module fsp_cs_decode #(
  parameter int DEV_CNT = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [IDX_W-1:0]   idx,
  output logic [DEV_CNT-1:0] cs_n
);
  for (genvar i = 0; i < DEV_CNT; i++) begin : g_line
    assign cs_n[i] = ~(en && (idx == IDX_W'(i)));
  end

  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R1
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (&cs_n));
endmodule

// File: rtl/fsp_poll_cnt.sv
module fsp_poll_cnt #(
  parameter int LIMIT = 16,
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int LIM_M1 = (LIMIT > 0) ? LIMIT - 1 : 0;

  logic [CNT_W-1:0] cnt;

  assign last = (LIMIT > 0) && (cnt == CNT_W'(LIM_M1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (inc && !last)    cnt <= cnt + 1'b1;
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LIMIT > 0) |-> (cnt <= CNT_W'(LIM_M1)));
endmodule

// File: rtl/flash_stat_poll.sv
module flash_stat_poll
  import fsp_pkg::*;
#(
  parameter int         DEV_CNT    = 4,
  parameter logic [7:0] DENS_CODE  = 8'h2C,
  parameter int         POLL_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode,
  input  logic [IDX_W-1:0]   dev_idx,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               fail,
  output logic               timeout,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  output logic [DEV_CNT-1:0] cs_n
);
  localparam int             CNT_W    = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEV_CNT - 1);

  // R12
  if (DEV_CNT < 1 || DEV_CNT > MAX_DEV) begin : g_bad_cnt
    $error("flash_stat_poll: DEV_CNT must be within 1..4");
  end

  fsp_state_e       state;
  fsp_mode_e        mode_q;
  logic [IDX_W-1:0] cur;
  logic             cs_en;
  logic             idx_bad;
  logic             dens_ok;
  logic             busy_rd;
  logic             start_go;
  logic             lim_last;

  assign busy     = (state != S_IDLE);
  assign cs_en    = (state == S_SEL) || (state == S_CMD) || (state == S_CMD_RX) ||
                    (state == S_DUMMY) || (state == S_STAT);
  assign tx_valid = (state == S_CMD) || (state == S_DUMMY);
  assign tx_data  = (state == S_CMD) ? OP_STATUS : FILL_BYTE;
  assign idx_bad  = {1'b0, dev_idx} >= (IDX_W + 1)'(DEV_CNT);
  assign dens_ok  = (rx_data & DENS_MASK) >= DENS_CODE;
  assign start_go = (state == S_IDLE) && start;
  assign busy_rd  = (state == S_STAT) && rx_valid && (mode_q == M_WAIT) &&
                    !rx_data[READY_BIT];

  fsp_cs_decode #(.DEV_CNT(DEV_CNT), .IDX_W(IDX_W)) u_cs (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cs_en),
    .idx  (cur),
    .cs_n (cs_n)
  );

  fsp_poll_cnt #(.LIMIT(POLL_LIMIT), .CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_go),
    .inc  (busy_rd),
    .last (lim_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mode_q  <= M_CHECK;
      cur     <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            pass    <= 1'b0;
            fail    <= 1'b0;
            timeout <= 1'b0;
            mode_q  <= mode ? M_WAIT : M_CHECK;
            if (mode && idx_bad) begin
              done <= 1'b1;
              fail <= 1'b1;
            end else begin
              cur   <= mode ? dev_idx : '0;
              state <= S_SEL;
            end
          end
        end
        S_SEL:    state <= S_CMD;
        S_CMD:    if (tx_ready) state <= S_CMD_RX;
        S_CMD_RX: if (rx_valid) state <= S_DUMMY;
        S_DUMMY:  if (tx_ready) state <= S_STAT;
        S_STAT: begin
          if (rx_valid) begin
            if (mode_q == M_CHECK) begin
              if (!dens_ok) begin
                state <= S_IDLE;
                done  <= 1'b1;
                fail  <= 1'b1;
              end else if (cur == LAST_IDX) begin
                state <= S_IDLE;
                done  <= 1'b1;
                pass  <= 1'b1;
              end else begin
                cur   <= cur + 1'b1;
                state <= S_GAP;
              end
            end else if (rx_data[READY_BIT]) begin
              state <= S_IDLE;
              done  <= 1'b1;
              pass  <= 1'b1;
            end else if (lim_last) begin
              state   <= S_IDLE;
              done    <= 1'b1;
              fail    <= 1'b1;
              timeout <= 1'b1;
            end else begin
              state <= S_DUMMY;
            end
          end
        end
        S_GAP:   state <= S_SEL;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4
  tx_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(&cs_n));

  // R7
  cs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && !lim_last) |=> $stable(cs_n));

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_valid && (&cs_n)));
endmodule

// File: tb/tb_flash_stat_poll.sv
module tb_flash_stat_poll;
  localparam int         NDEV = 3;
  localparam logic [7:0] DENS = 8'h34;
  localparam int         LIM  = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, mode;
  logic [1:0] dev_idx;
  logic       busy, done, pass, fail, timeout;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic [NDEV-1:0] cs_n;

  always #4 clk = ~clk;

  flash_stat_poll #(.DEV_CNT(NDEV), .DENS_CODE(DENS), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dev_idx(dev_idx),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .timeout(timeout),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;

  // responder configuration, written by the stimulus
  int         lat = 0;
  logic [7:0] dev_stat [0:3];
  int         busy_need [0:3];

  // responder bookkeeping, written only by the responder
  int         n_cmd = 0, n_dummy = 0, n_bad = 0, nvis = 0;
  int         vlog [0:255];
  int         poll_seen [0:3];
  logic       expect_cmd = 1'b0;
  logic [NDEV-1:0] cs_q;
  logic       pend;
  int         dly;
  logic [7:0] pdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      tx_ready <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= 8'h00;
      cs_q     <= '1;
      dly      <= 0;
      pdata    <= 8'h00;
    end else begin
      cs_q <= cs_n;
      for (int i = 0; i < NDEV; i++) begin
        if (cs_q[i] && !cs_n[i]) begin
          vlog[nvis & 255] = i;
          nvis++;
          expect_cmd = 1'b1;
        end
      end
      if ($countones(~cs_n) > 1) n_bad++;
      rx_valid <= 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rx_valid <= 1'b1;
          rx_data  <= pdata;
          pend     <= 1'b0;
          tx_ready <= 1'b1;
        end else begin
          dly <= dly - 1;
        end
      end else if (tx_valid && tx_ready) begin
        automatic int sel = -1;
        automatic logic [7:0] s;
        for (int i = 0; i < NDEV; i++) if (!cs_n[i]) sel = i;
        if (sel < 0) begin
          n_bad++;
          sel = 0;
        end
        if (expect_cmd) begin
          if (tx_data != 8'hD7) n_bad++;
          expect_cmd = 1'b0;
          n_cmd++;
          poll_seen[sel] = 0;
          pdata <= 8'h00;
        end else begin
          if (tx_data != 8'hFF) n_bad++;
          n_dummy++;
          s = dev_stat[sel];
          s[7] = (poll_seen[sel] >= busy_need[sel]);
          poll_seen[sel]++;
          pdata <= s;
        end
        pend     <= 1'b1;
        tx_ready <= 1'b0;
        dly      <= lat;
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  logic r_pass, r_fail, r_tmo, r_hold, r_busy_inj;
  int   d_cmd, d_dummy, d_vis, v0;

  task automatic run_op(input logic m, input logic [1:0] idx, input int inject);
    int c0, u0, cyc;
    c0 = n_cmd; u0 = n_dummy; v0 = nvis;
    r_busy_inj = 1'b1;
    @(negedge clk);
    start = 1'b1; mode = m; dev_idx = idx;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      if (inject > 0 && cyc == inject) begin
        r_busy_inj = busy;
        start = 1'b1; mode = ~m; dev_idx = 2'd0;
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    chk("R11", "done seen", int'(done), 1);
    r_pass = pass; r_fail = fail; r_tmo = timeout;
    repeat (3) @(negedge clk);
    r_hold = !done && (pass == r_pass) && (fail == r_fail) && (timeout == r_tmo);
    d_cmd = n_cmd - c0; d_dummy = n_dummy - u0; d_vis = nvis - v0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 got hang expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; dev_idx = 2'd0;
    for (int i = 0; i < 4; i++) begin dev_stat[i] = 8'h3C; busy_need[i] = 0; end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n idle", int'(cs_n), (1 << NDEV) - 1);
    chk("R1", "tx_valid idle", int'(tx_valid), 0);
    chk("R1", "busy idle", int'(busy), 0);
    chk("R1", "done idle", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int li = 0; li < 2; li++) begin
      lat = li * 3;
      // R5 R6 scan sweep: failing position f (NDEV = none) x bad value
      for (int f = 0; f <= NDEV; f++) begin
        for (int bv = 0; bv < 4; bv++) begin
          automatic logic [7:0] badv;
          automatic int first_bad = NDEV;
          case (bv)
            0: badv = 8'h30;
            1: badv = 8'hCB;
            2: badv = 8'h33;
            default: badv = 8'hF7;
          endcase
          for (int i = 0; i < 4; i++) begin
            dev_stat[i]  = (i % 2 == 1) ? 8'hF7 : 8'h38;
            busy_need[i] = i % 2;
          end
          if (f < NDEV) dev_stat[f] = badv;
          for (int i = NDEV - 1; i >= 0; i--)
            if ((dev_stat[i] & 8'h3C) < DENS) first_bad = i;
          run_op(1'b0, 2'd0, 0);
          chk("R6", "scan pass", int'(r_pass), int'(first_bad == NDEV));
          chk("R6", "scan fail", int'(r_fail), int'(first_bad != NDEV));
          chk("R8", "scan timeout", int'(r_tmo), 0);
          chk("R5", "devices visited", d_vis, (first_bad == NDEV) ? NDEV : first_bad + 1);
          for (int k = 0; k < d_vis && k < NDEV; k++)
            chk("R5", "visit order", vlog[(v0 + k) & 255], k);
          chk("R2", "opcodes per scan", d_cmd, d_vis);
          chk("R2", "status samples per scan", d_dummy, d_vis);
          chk("R11", "result held", int'(r_hold), 1);
        end
      end
      // R7 R8 R9 wait sweep
      for (int idx = 0; idx < 4; idx++) begin
        for (int ni = 0; ni < 6; ni++) begin
          automatic int nb;
          case (ni)
            0: nb = 0; 1: nb = 1; 2: nb = 3; 3: nb = LIM - 1; 4: nb = LIM;
            default: nb = LIM + 1;
          endcase
          for (int i = 0; i < 4; i++) begin dev_stat[i] = 8'h00; busy_need[i] = 0; end
          if (idx < NDEV) busy_need[idx] = nb;
          run_op(1'b1, 2'(idx), 0);
          if (idx >= NDEV) begin
            chk("R9", "bad index fail", int'(r_fail), 1);
            chk("R9", "bad index pass", int'(r_pass), 0);
            chk("R9", "bad index selects", d_vis, 0);
            chk("R9", "bad index bytes", d_cmd + d_dummy, 0);
          end else begin
            chk("R7", "wait pass", int'(r_pass), int'(nb < LIM));
            chk("R8", "wait timeout", int'(r_tmo), int'(nb >= LIM));
            chk("R8", "wait fail", int'(r_fail), int'(nb >= LIM));
            chk("R7", "samples", d_dummy, (nb < LIM) ? nb + 1 : LIM);
            chk("R7", "single selection", d_vis, 1);
            chk("R4", "selected line", vlog[v0 & 255], idx);
            chk("R2", "one opcode", d_cmd, 1);
          end
          chk("R11", "result held", int'(r_hold), 1);
        end
      end
    end

    // R10 start while busy ignored
    lat = 2;
    for (int i = 0; i < 4; i++) begin dev_stat[i] = 8'h00; busy_need[i] = 0; end
    busy_need[1] = 5;
    run_op(1'b1, 2'd1, 6);
    chk("R10", "busy at injected start", int'(r_busy_inj), 1);
    chk("R10", "result pass", int'(r_pass), 1);
    chk("R10", "samples unchanged", d_dummy, 6);
    chk("R10", "selections unchanged", d_vis, 1);
    repeat (4) @(negedge clk);
    chk("R10", "idle after job", int'(busy), 0);
    chk("R1", "cs_n idle after jobs", int'(cs_n), (1 << NDEV) - 1);
    chk("R2", "protocol violations", n_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule